// File: doc/BRIEF.md
# RGB Channel Multiplex Sequencer

This block produces the 2-bit select that decides which of three sampled colour channels (red, green, blue) is passed to a single shared converter. It takes two sampling strobes from the sensor timing: a reset-sample strobe, which marks the start of each pixel, and a data-sample strobe. Both are brought into the block clock domain through a synchroniser, and only their high-to-low transitions are used.

In three-colour mode, every falling reset-sample strobe restarts the select at the first colour of the programmed order. Every falling data-sample strobe then steps the select one colour onward. Once the last colour is reached, the select stays there until the next restart. In single-colour mode the select is pinned to one configured channel.

On each falling data-sample strobe the block also raises a one-cycle tag pulse. The pulse carries the colour the select has just moved to, so that the downstream logic can label the converted sample with its colour.

Top module: `rgb_mux_sequencer`

## Requirements
- R1: After synchronous reset, `chan_sel` is 00 (red) and `tag_valid` is low.
- R2: In three-colour mode with `order_rev`=0, successive data-strobe falls after a restart move `chan_sel` from red (00) to green (01) and then to blue (10).
- R3: A reset-strobe fall in three-colour mode returns `chan_sel` to the first colour of the order: red (00) when `order_rev`=0, blue (10) when `order_rev`=1.
- R4: In three-colour mode with `order_rev`=1, successive data-strobe falls after a restart move `chan_sel` from blue (10) to green (01) and then to red (00).
- R5: Once the last colour of the order is reached, further data-strobe falls leave `chan_sel` at that colour until the next reset-strobe fall.
- R6: With `one_chan_mode`=1, `chan_sel` follows `fixed_sel` one clock later (00 red, 01 green, 10 blue), whatever the strobes do. `chan_sel` never shows the value 11.
- R7: With `one_chan_mode`=1, a `fixed_sel` value of 11 selects red (00).
- R8: Every data-strobe fall produces exactly one `tag_valid` pulse, one cycle wide, in either mode. In that cycle `tag_chan` equals the new `chan_sel`.
- R9: When both strobes fall in the same clock cycle, the restart wins. `chan_sel` and `tag_chan` show the first colour of the order.
- R10: A strobe fall first sampled at rising edge k changes `chan_sel` at edge k+SYNC_STAGES, which is k+2 at the default. Back-to-back fall detections cannot occur.
- R11: A strobe that rises or stays at a constant level changes nothing: there is no step and no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ck_reset_smp | input | 1 | Reset-sample strobe, asynchronous; its fall restarts the sequence |
| ck_data_smp | input | 1 | Data-sample strobe, asynchronous; its fall steps the sequence |
| one_chan_mode | input | 1 | 1 = single-colour mode, 0 = three-colour mode |
| fixed_sel | input | 2 | Colour used in single-colour mode |
| order_rev | input | 1 | 0 = red, green, blue; 1 = blue, green, red |
| chan_sel | output | 2 | Colour select: 00 red, 01 green, 10 blue |
| tag_valid | output | 1 | One-cycle pulse per data-strobe fall |
| tag_chan | output | 2 | Colour carried by the tag pulse |

## Verification
The hardest situation to reach from the ports is two strobes falling in exactly the same clock cycle. That collision decides whether the restart or the step wins. The bench releases both strobes on the same falling clock edge, so both pass through identical synchroniser chains and arrive at the sequencer together. A second hard case is the exact cycle in which a strobe fall reaches the output. To pin it down, the bench releases one strobe and samples `chan_sel` between each of the next rising edges.

// File: rtl/rgb_seq_pkg.sv
// Shared colour codes and the order-mapping function for the channel sequencer.
package rgb_seq_pkg;
    typedef enum logic [1:0] {
        COL_RED   = 2'b00,
        COL_GREEN = 2'b01,
        COL_BLUE  = 2'b10
    } colour_e;

    // Map a step position (0 = first colour) onto a colour code for a given order.
    function automatic logic [1:0] step_to_colour(input logic [1:0] step, input logic rev);
        logic [1:0] c;
        c = rev ? (2'd2 - step) : step;
        return c;
    endfunction
endpackage

// File: rtl/seq_edge_detect.sv
// seq_edge_detect: synchronises one asynchronous strobe and pulses `fall`
// for one cycle when the synchronised level goes from high to low.
// Assumes the strobe stays at each level for at least two clock cycles.
module seq_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchroniser chain: stage 0 samples the pin, each later stage copies the one before it.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else if (g == 0) sync_q[g] <= strobe_in;
                else sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    // Keep the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign fall = prev_q & ~sync_q[LAST];

    // Two fall detections can never come in consecutive cycles.
    assert_single_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/seq_step_ctr.sv
// seq_step_ctr: holds the position within a pixel (0 = first colour).
// Restart clears it, step advances it and saturates at the last position;
// restart takes priority when both arrive together.
module seq_step_ctr #(
    parameter int NUM_COLOURS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       step,
    output logic [1:0] pos_q,
    output logic [1:0] pos_next
);
    localparam logic [1:0] LAST_POS = 2'(NUM_COLOURS - 1);

    // Next position: restart first, then saturating step, else hold.
    always_comb begin
        if (restart)                       pos_next = 2'd0;
        else if (step && pos_q != LAST_POS) pos_next = pos_q + 2'd1;
        else                                pos_next = pos_q;
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= 2'd0;
        else        pos_q <= pos_next;
    end

    assert_restart_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> pos_q == 2'd0);
    assert_step_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && pos_q != LAST_POS) |=> pos_q == $past(pos_q) + 2'd1);
    assert_saturate_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && pos_q == LAST_POS) |=> pos_q == LAST_POS);
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(pos_q));
endmodule

// File: rtl/seq_chan_map.sv
// seq_chan_map: turns a step position and configuration into a colour code.
// Single-colour mode uses the fixed code, with 11 folded onto red.
module seq_chan_map
    import rgb_seq_pkg::*;
(
    input  logic [1:0] pos,
    input  logic       one_chan_mode,
    input  logic [1:0] fixed_sel,
    input  logic       order_rev,
    output logic [1:0] colour
);
    // Choose fixed or sequenced colour.
    always_comb begin
        if (one_chan_mode) colour = (fixed_sel == 2'b11) ? COL_RED : fixed_sel;
        else               colour = step_to_colour(pos, order_rev);
    end
endmodule

// File: rtl/rgb_mux_sequencer.sv
// rgb_mux_sequencer: top level. Detects strobe falls, keeps the colour
// position and registers the select and the colour tag.
// Assumes both strobes come from the same timing source and are slow
// relative to clk.
module rgb_mux_sequencer #(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_COLOURS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ck_reset_smp,
    input  logic       ck_data_smp,
    input  logic       one_chan_mode,
    input  logic [1:0] fixed_sel,
    input  logic       order_rev,
    output logic [1:0] chan_sel,
    output logic       tag_valid,
    output logic [1:0] tag_chan
);
    logic       restart_fall;
    logic       step_fall;
    logic [1:0] pos_q;
    logic [1:0] pos_next;
    logic [1:0] colour_next;

    seq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) i_restart_edge (
        .clk(clk), .rst_n(rst_n), .strobe_in(ck_reset_smp), .fall(restart_fall));

    seq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) i_step_edge (
        .clk(clk), .rst_n(rst_n), .strobe_in(ck_data_smp), .fall(step_fall));

    seq_step_ctr #(.NUM_COLOURS(NUM_COLOURS)) i_step_ctr (
        .clk(clk), .rst_n(rst_n), .restart(restart_fall), .step(step_fall),
        .pos_q(pos_q), .pos_next(pos_next));

    seq_chan_map i_chan_map (
        .pos(pos_next), .one_chan_mode(one_chan_mode), .fixed_sel(fixed_sel),
        .order_rev(order_rev), .colour(colour_next));

    // Register the select every cycle from the next position and current configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) chan_sel <= 2'b00;
        else        chan_sel <= colour_next;
    end

    // Raise the tag for one cycle on each data-strobe fall, carrying the new colour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_valid <= 1'b0;
            tag_chan  <= 2'b00;
        end else begin
            tag_valid <= step_fall;
            if (step_fall) tag_chan <= colour_next;
        end
    end

    assert_tag_matches_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> tag_chan == chan_sel);
    assert_tag_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> !tag_valid);
    assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chan_sel != 2'b11);
endmodule

// File: tb/test_rgb_mux_sequencer.sv
module test_rgb_mux_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ck_reset_smp = 1'b0;
    logic       ck_data_smp = 1'b0;
    logic       one_chan_mode = 1'b0;
    logic [1:0] fixed_sel = 2'b00;
    logic       order_rev = 1'b0;
    logic [1:0] chan_sel;
    logic       tag_valid;
    logic [1:0] tag_chan;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] exp_q[$];
    logic tag_prev = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rgb_mux_sequencer i_rgb_mux_sequencer (
        .clk(clk), .rst_n(rst_n), .ck_reset_smp(ck_reset_smp), .ck_data_smp(ck_data_smp),
        .one_chan_mode(one_chan_mode), .fixed_sel(fixed_sel), .order_rev(order_rev),
        .chan_sel(chan_sel), .tag_valid(tag_valid), .tag_chan(tag_chan));

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop the expected tag for every tag pulse and check the pulse width.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (tag_valid) begin
                if (tag_prev) check("R8 width", 2'd1, 2'd0);
                if (exp_q.size() == 0) check("R11 unexpected tag", tag_chan, 2'd3);
                else check("R8 tag colour", tag_chan, exp_q.pop_front());
            end
            tag_prev <= tag_valid;
        end
    end

    // Driver: one strobe pulse; sel 0 = reset strobe, 1 = data strobe, 2 = both.
    task automatic pulse(input int sel, input bit expect_tag, input logic [1:0] tag_exp);
        @(negedge clk);
        if (sel != 1) ck_reset_smp = 1'b1;
        if (sel != 0) ck_data_smp = 1'b1;
        repeat (3) @(negedge clk);
        if (expect_tag) exp_q.push_back(tag_exp);
        ck_reset_smp = 1'b0;
        ck_data_smp = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset sel", chan_sel, 2'b00);
        check("R1 reset tag", {1'b0, tag_valid}, 2'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Three-colour, forward order.
        pulse(0, 0, 2'b00); check("R3 restart red", chan_sel, 2'b00);
        pulse(1, 1, 2'b01); check("R2 green", chan_sel, 2'b01);
        pulse(1, 1, 2'b10); check("R2 blue", chan_sel, 2'b10);
        pulse(1, 1, 2'b10); check("R5 saturate", chan_sel, 2'b10);
        pulse(0, 0, 2'b00); check("R3 restart red again", chan_sel, 2'b00);

        // Latency: release the data strobe and watch edge by edge.
        @(negedge clk); ck_data_smp = 1'b1;
        repeat (3) @(negedge clk);
        exp_q.push_back(2'b01);
        ck_data_smp = 1'b0;
        @(negedge clk); check("R10 after edge k", chan_sel, 2'b00);
        @(negedge clk); check("R10 after edge k+1", chan_sel, 2'b00);
        @(negedge clk); check("R10 after edge k+2", chan_sel, 2'b01);
        repeat (4) @(negedge clk);

        // A held-high strobe and its rising edge must not step.
        @(negedge clk); ck_data_smp = 1'b1;
        repeat (8) @(negedge clk);
        check("R11 rise and level hold", chan_sel, 2'b01);
        exp_q.push_back(2'b10);
        ck_data_smp = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 later fall steps", chan_sel, 2'b10);

        // Reverse order.
        order_rev = 1'b1;
        pulse(0, 0, 2'b00); check("R3 restart blue", chan_sel, 2'b10);
        pulse(1, 1, 2'b01); check("R4 green", chan_sel, 2'b01);
        pulse(1, 1, 2'b00); check("R4 red", chan_sel, 2'b00);
        pulse(1, 1, 2'b00); check("R5 saturate reverse", chan_sel, 2'b00);

        // Both strobes fall together: restart wins.
        pulse(2, 1, 2'b10); check("R9 collision", chan_sel, 2'b10);

        // Single-colour mode.
        one_chan_mode = 1'b1;
        fixed_sel = 2'b00; repeat (2) @(negedge clk); check("R6 fixed red", chan_sel, 2'b00);
        fixed_sel = 2'b01; repeat (2) @(negedge clk); check("R6 fixed green", chan_sel, 2'b01);
        fixed_sel = 2'b10; repeat (2) @(negedge clk); check("R6 fixed blue", chan_sel, 2'b10);
        fixed_sel = 2'b11; repeat (2) @(negedge clk); check("R7 code 11 red", chan_sel, 2'b00);
        fixed_sel = 2'b01;
        pulse(1, 1, 2'b01); check("R8 single-mode step holds", chan_sel, 2'b01);
        pulse(0, 0, 2'b00); check("R6 single-mode restart holds", chan_sel, 2'b01);

        // Back to three-colour forward order.
        one_chan_mode = 1'b0;
        order_rev = 1'b0;
        pulse(0, 0, 2'b00); check("R3 restart after mode change", chan_sel, 2'b00);

        check("R8 all tags seen", 2'(exp_q.size()), 2'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule